// File: doc/BRIEF.md
# Overcurrent Deglitch and Auto-Retry Controller

This block sits between a set of overcurrent comparators and the enable of a power-stage driver. Each power switch has its own comparator flag. A switch's flag is only taken into account while that switch's gate is commanded on. A separate flag from the current-sense pin is taken into account at all times. When any qualifying flag stays high for longer than a programmable deglitch time, the block declares an overcurrent fault.

On a fault the block drives its active-low fault pin low and removes the driver enable. It holds both for a fixed retry interval, which is 5 ms measured in cycles of the block clock, and then releases them without any action from software. A sticky status bit records that a fault happened. Software clears it by writing a zero through a one-bit write port. Flags seen during the retry interval are ignored, and qualification starts again from zero once the interval ends.

Top module: `ocp_retry_ctrl`

## Requirements
- R1: While reset is applied, and after it is released with no flag high, `drv_en` is 1, `fault_n` is 1 and `oc_status` is 0.
- R2: Bit i of `oc_sw` qualifies only while bit i of `gate_on` is 1. A switch flag whose own gate is off causes no fault, even when other gates are on. `oc_sense` qualifies regardless of the gates.
- R3: A fault is declared on the clock edge that sees a qualifying condition for the (`deg_sel`+1)th consecutive edge. If the condition drops for a single edge, the count restarts from zero.
- R4: After the edge that declares a fault, `fault_n` is 0 and `drv_en` is 0. Both change together on that edge.
- R5: `fault_n` and `drv_en` stay low for exactly RETRY_CYC = CLK_HZ*RETRY_US/1000000 clock edges, counting the declaring edge. After that, both return to 1 with no software action. The default RETRY_US is 5000.
- R6: `oc_status` becomes 1 on the edge that declares a fault. It stays 1 until an edge where `wr_en`=1 and `wr_data`=0.
- R7: A write with `wr_en`=1 and `wr_data`=1 leaves `oc_status` unchanged.
- R8: If a fault is declared on the same edge as a clearing write, `oc_status` ends up 1.
- R9: While the retry interval runs, qualifying flags neither declare a fault nor set `oc_status`. After release, a condition that is still present needs a fresh (`deg_sel`+1) edges to trip again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oc_sw | input | N_SW | Per-switch overcurrent comparator flags |
| gate_on | input | N_SW | Per-switch gate command; 1 = switch driven |
| oc_sense | input | 1 | Current-sense pin overcurrent flag |
| deg_sel | input | DEG_W | Deglitch length; a fault needs deg_sel+1 consecutive edges |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 1 | Status write value; 0 clears, 1 has no effect |
| drv_en | output | 1 | Driver enable, 0 during retry |
| fault_n | output | 1 | Active-low fault pin, 0 during retry |
| oc_status | output | 1 | Sticky overcurrent status bit |

## Verification
Suppose the deglitch count is off by one. The bench would then see `fault_n` fall one edge early or late after a steady flag starts, and the directed tests sample on both sides of that edge. Suppose the retry counter or state is wrong. The bench would then see the release move away from exactly RETRY_CYC edges after the trip, which is checked on the last low edge and the first high edge. Suppose the gating, the stickiness or the disarming during retry is broken. That shows within one edge as a stray fall of `fault_n` or a wrong `oc_status` value, sampled right after the stimulus that could have disturbed it.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    ST_MON   = 1'b0,
    ST_RETRY = 1'b1
  } retry_st_e;
endpackage

// File: rtl/ocp_qualify.sv
module ocp_qualify #(
  parameter int N_SW = 6
) (
  input  logic [N_SW-1:0] oc_sw,
  input  logic [N_SW-1:0] gate_on,
  input  logic            oc_sense,
  output logic            cond
);
  logic [N_SW-1:0] qual;

  for (genvar g = 0; g < N_SW; g++) begin : g_sw
    // a switch flag only counts while that switch is driven (R2)
    assign qual[g] = oc_sw[g] & gate_on[g];
  end

  assign cond = (|qual) | oc_sense;
endmodule

// File: rtl/ocp_deglitch.sv
module ocp_deglitch #(
  parameter int DEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             cond,
  input  logic [DEG_W-1:0] deg_sel,
  output logic             trip
);
  logic [DEG_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!arm || !cond) begin
      cnt_d = '0;
    end else if (cnt_q != deg_sel) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign trip = arm && cond && (cnt_q == deg_sel);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> (cnt_q == '0)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    arm && cond && $stable(deg_sel) |=> (cnt_q <= deg_sel)); // R3
endmodule

// File: rtl/ocp_retry_fsm.sv
module ocp_retry_fsm
  import ocp_pkg::*;
#(
  parameter longint RETRY_CYC = 64'd1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  output logic retry_active
);
  localparam int RCW = (RETRY_CYC > 2) ? $clog2(RETRY_CYC) : 1;
  localparam logic [RCW-1:0] LAST = RCW'(RETRY_CYC - 1);

  retry_st_e      st_q, st_d;
  logic [RCW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_MON: begin
        if (trip) begin
          st_d   = ST_RETRY;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_RETRY: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          st_d  = ST_MON;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_MON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_MON;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign retry_active = (st_q == ST_RETRY);

  AST_RETRY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MON) && trip |=> (st_q == ST_RETRY) && (cnt_q == '0)); // R4
  AST_RETRY_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R5
  AST_RETRY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RETRY) && (cnt_q == LAST) |=> (st_q == ST_MON)); // R5
  AST_RETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RETRY) && (cnt_q != LAST) |=> (st_q == ST_RETRY)); // R5
endmodule

// File: rtl/ocp_retry_ctrl.sv
module ocp_retry_ctrl #(
  parameter int     N_SW     = 6,
  parameter int     DEG_W    = 8,
  parameter longint CLK_HZ   = 64'd250000000,
  parameter longint RETRY_US = 64'd5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SW-1:0]  oc_sw,
  input  logic [N_SW-1:0]  gate_on,
  input  logic             oc_sense,
  input  logic [DEG_W-1:0] deg_sel,
  input  logic             wr_en,
  input  logic             wr_data,
  output logic             drv_en,
  output logic             fault_n,
  output logic             oc_status
);
  localparam longint RETRY_CYC = (CLK_HZ * RETRY_US) / 64'd1000000;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cond, trip, retry_active;
  logic       stat_d, stat_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ocp_qualify #(.N_SW(N_SW)) u_qual (
    .oc_sw    (oc_sw),
    .gate_on  (gate_on),
    .oc_sense (oc_sense),
    .cond     (cond)
  );

  ocp_deglitch #(.DEG_W(DEG_W)) u_deg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .arm     (!retry_active),
    .cond    (cond),
    .deg_sel (deg_sel),
    .trip    (trip)
  );

  ocp_retry_fsm #(.RETRY_CYC(RETRY_CYC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .trip         (trip),
    .retry_active (retry_active)
  );

  // sticky status: set has priority over a write of zero
  always_comb begin
    stat_en = 1'b0;
    stat_d  = oc_status;
    if (trip) begin
      stat_en = 1'b1;
      stat_d  = 1'b1;
    end else if (wr_en && !wr_data) begin
      stat_en = 1'b1;
      stat_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      oc_status <= 1'b0;
    end else if (stat_en) begin
      oc_status <= stat_d;
    end
  end

  assign drv_en  = !retry_active;
  assign fault_n = !retry_active;

  AST_TRIP_DISABLES: assert property (@(posedge clk) disable iff (!rst_int_n)
    trip |=> !drv_en && !fault_n); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    trip |=> oc_status); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    oc_status && !(wr_en && !wr_data) |=> oc_status); // R6
  AST_WRITE_ONE_NOOP: assert property (@(posedge clk) disable iff (!rst_int_n)
    !oc_status && wr_en && wr_data && fault_n && !cond |=> !oc_status); // R7
  AST_IGNORE_IN_RETRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fault_n && wr_en && !wr_data |=> !oc_status); // R9
endmodule

// File: tb/ocp_retry_ctrl_test.sv
module ocp_retry_ctrl_test;
  localparam int     N_SW   = 6;
  localparam int     DEG_W  = 8;
  localparam longint CLK_HZ = 64'd1000000;
  localparam int     RC     = int'((CLK_HZ * 64'd5000) / 64'd1000000);
  localparam int     DEG    = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N_SW-1:0]  oc_sw, gate_on;
  logic             oc_sense;
  logic [DEG_W-1:0] deg_sel;
  logic             wr_en, wr_data;
  logic             drv_en, fault_n, oc_status;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ocp_retry_ctrl #(.N_SW(N_SW), .DEG_W(DEG_W), .CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .oc_sw(oc_sw), .gate_on(gate_on),
    .oc_sense(oc_sense), .deg_sel(deg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .drv_en(drv_en), .fault_n(fault_n), .oc_status(oc_status)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; oc_sw = '0; gate_on = '0; oc_sense = 1'b0;
    deg_sel = DEG_W'(DEG); wr_en = 1'b0; wr_data = 1'b0;
    edges(4);
    chk("R1", "drv_en in reset", drv_en, 1'b1);
    chk("R1", "fault_n in reset", fault_n, 1'b1);
    chk("R1", "oc_status in reset", oc_status, 1'b0);
    rst_n = 1'b1;
    edges(4);
    chk("R1", "drv_en after reset", drv_en, 1'b1);
    chk("R1", "oc_status after reset", oc_status, 1'b0);
  endtask

  // R2 gating, then R3 timing, R4, R5, R6 on a single trip
  task automatic t_gate_and_trip;
    oc_sw = 6'b000100;
    gate_on = '0;
    edges(20);
    chk("R2", "flag with all gates off", fault_n, 1'b1);
    gate_on = 6'b000010;
    edges(20);
    chk("R2", "flag with other gate on", fault_n, 1'b1);
    gate_on = 6'b000110;
    edges(DEG);
    chk("R3", "fault_n one edge before deglitch end", fault_n, 1'b1);
    edges(1);
    chk("R3", "fault_n at deglitch end", fault_n, 1'b0);
    chk("R4", "drv_en after trip", drv_en, 1'b0);
    chk("R6", "status after trip", oc_status, 1'b1);
    oc_sw = '0; gate_on = '0;
    edges(RC - 1);
    chk("R5", "fault_n on last retry edge", fault_n, 1'b0);
    chk("R5", "drv_en on last retry edge", drv_en, 1'b0);
    edges(1);
    chk("R5", "fault_n released", fault_n, 1'b1);
    chk("R5", "drv_en released", drv_en, 1'b1);
    chk("R6", "status stays after release", oc_status, 1'b1);
  endtask

  task automatic t_glitch;
    for (int k = 0; k < 3; k++) begin
      oc_sense = 1'b1;
      edges(DEG);
      oc_sense = 1'b0;
      edges(1);
    end
    chk("R3", "interrupted condition does not trip", fault_n, 1'b1);
    chk("R3", "interrupted condition keeps drv_en", drv_en, 1'b1);
  endtask

  task automatic t_status_write;
    wr_en = 1'b1; wr_data = 1'b1;
    edges(1);
    wr_en = 1'b0;
    edges(1);
    chk("R7", "write one leaves status set", oc_status, 1'b1);
    wr_en = 1'b1; wr_data = 1'b0;
    edges(1);
    wr_en = 1'b0;
    edges(1);
    chk("R6", "write zero clears status", oc_status, 1'b0);
    wr_en = 1'b1; wr_data = 1'b1;
    edges(1);
    wr_en = 1'b0;
    edges(1);
    chk("R7", "write one leaves status clear", oc_status, 1'b0);
  endtask

  task automatic t_retry_ignore;
    oc_sense = 1'b1;
    edges(DEG + 1);
    chk("R4", "sense trip pulls fault_n", fault_n, 1'b0);
    wr_en = 1'b1; wr_data = 1'b0;
    edges(1);
    wr_en = 1'b0;
    edges(10);
    chk("R9", "held flag ignored during retry", oc_status, 1'b0);
    edges(RC - 12);
    chk("R9", "still in retry on last edge", fault_n, 1'b0);
    edges(1);
    chk("R9", "released with flag still high", fault_n, 1'b1);
    edges(DEG);
    chk("R9", "fresh deglitch not yet done", fault_n, 1'b1);
    edges(1);
    chk("R9", "retrips after fresh deglitch", fault_n, 1'b0);
    chk("R9", "status set by retrip", oc_status, 1'b1);
    oc_sense = 1'b0;
    edges(RC);
    chk("R5", "second release", drv_en, 1'b1);
  endtask

  task automatic t_collision;
    wr_en = 1'b1; wr_data = 1'b0;
    edges(1);
    wr_en = 1'b0;
    chk("R6", "cleared before collision", oc_status, 1'b0);
    oc_sense = 1'b1;
    edges(DEG);
    wr_en = 1'b1; wr_data = 1'b0;
    edges(1);
    wr_en = 1'b0; oc_sense = 1'b0;
    chk("R8", "set wins over clear", oc_status, 1'b1);
    chk("R4", "collision trip drops drv_en", drv_en, 1'b0);
    edges(RC);
    chk("R5", "collision retry release", fault_n, 1'b1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_gate_and_trip();
    t_glitch();
    t_status_write();
    t_retry_ignore();
    t_collision();
    finish_run();
  end
endmodule